// File: doc/BRIEF.md
# AC97 Serial Frame Controller

This block is the controller end of an AC97 audio link. It runs entirely on the bit clock supplied by the codec. It produces the SYNC pulse that opens each 256-bit frame. It shifts out a tag slot followed by twelve 20-bit data slots, and it reassembles the same structure from the codec's serial return stream.

On the transmit side the system supplies two raw command words and a stereo pair of 18-bit PCM samples, each with a valid flag. These are captured once per frame and turned into slot contents and matching tag bits. On the receive side the tag, the two status words and the two PCM samples of each completed frame are presented on parallel outputs. These outputs are refreshed together with a one-cycle frame strobe. The same strobe also marks the point where the next transmit words are taken. Outgoing bits change on rising bit-clock edges, and incoming bits are captured on falling edges.

Top module: `aclink_frame_ctrl`

## Requirements
- R1: SYNC rising edges are exactly 256 bit clocks apart. SYNC never rises before a full 256-bit frame has been sent.
- R2: Each SYNC pulse stays high for 16 consecutive bit clocks and then low for 240.
- R3: Frame bit 0 is the tag's valid-frame bit. It is launched on the rising edge that follows the edge which raised SYNC. Each later rising edge launches the next bit: the 16 tag bits MSB first, then slots 1 to 12, each 20 bits MSB first.
- R4: Tag encoding, with tag bit 15 sent first. Bit 15 = tx_cmd_valid_i OR tx_pcm_valid_i. Bits 14 and 13 = tx_cmd_valid_i. Bits 12 and 11 = tx_pcm_valid_i. Bits 10..0 = 0.
- R5: Slot 1 carries tx_cmd_addr_i and slot 2 carries tx_cmd_data_i when tx_cmd_valid_i is set. Both slots are all zero otherwise.
- R6: Slot 3 carries tx_left_i and slot 4 carries tx_right_i in slot bits 19..2, with bits 1..0 zero. Both slots are all zero when tx_pcm_valid_i is clear. Slots 5 to 12 are always zero.
- R7: Transmit inputs are sampled at the rising edge where frame_done_o goes high. The frame launched from that edge carries them, and changes made later in the frame do not affect it.
- R8: frame_done_o is high for exactly one bit clock per frame. It rises at the same edge that launches frame bit 0.
- R9: Incoming bits are captured on falling edges, aligned with the outgoing frame: bit k arrives in the same bit period as outgoing bit k. rx_tag_o, rx_stat_addr_o (slot 1), rx_stat_data_o (slot 2), rx_left_o (slot 3 bits 19..2) and rx_right_o (slot 4 bits 19..2) take the values of the frame just completed at the edge where frame_done_o rises. They hold those values until the next such edge.
- R10: While rst_ni is low, sync_o, sdata_out_o, frame_done_o and all receive outputs are zero. SYNC rises at the first rising bit-clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock from the codec |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_in_i | input | 1 | Serial frame data from the codec |
| sync_o | output | 1 | Frame sync to the codec |
| sdata_out_o | output | 1 | Serial frame data to the codec |
| frame_done_o | output | 1 | One-cycle strobe per frame |
| tx_cmd_valid_i | input | 1 | Slots 1 and 2 carry command words |
| tx_cmd_addr_i | input | 20 | Raw slot 1 word |
| tx_cmd_data_i | input | 20 | Raw slot 2 word |
| tx_pcm_valid_i | input | 1 | Slots 3 and 4 carry a new sample pair |
| tx_left_i | input | 18 | Left sample to transmit |
| tx_right_i | input | 18 | Right sample to transmit |
| rx_tag_o | output | 16 | Received tag slot |
| rx_stat_addr_o | output | 20 | Received slot 1 word |
| rx_stat_data_o | output | 20 | Received slot 2 word |
| rx_left_o | output | 18 | Received left sample |
| rx_right_o | output | 18 | Received right sample |

## Verification
SYNC rises at the first rising edge after reset. Frame bit k leaves on the k-th rising edge after the frame boundary. frame_done_o, the refreshed receive words and the capture of the transmit words all fall on the edge that launches bit 0, which is one bit clock after SYNC rises. The bench acts as the codec. It drives each incoming bit just after a rising edge and reads SYNC, the serial output, the strobe and the parallel outputs only on the following falling edge. This places every sample half a period after the register that produced it. Receive words are checked on the frame after they were sent and again mid-frame. The transmit inputs are changed a few bits into one frame so that the sampling point is exercised.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int unsigned TAG_BITS_DEF    = 16;
  localparam int unsigned SLOT_BITS_DEF   = 20;
  localparam int unsigned NUM_SLOTS_DEF   = 12;
  localparam int unsigned SAMPLE_BITS_DEF = 18;

  // slot roles; tag bit (TAG_BITS-1-slot) flags slot validity
  localparam int unsigned SLOT_TAG       = 0;
  localparam int unsigned SLOT_CMD_ADDR  = 1;
  localparam int unsigned SLOT_CMD_DATA  = 2;
  localparam int unsigned SLOT_PCM_L     = 3;
  localparam int unsigned SLOT_PCM_R     = 4;
  localparam int unsigned LAST_USED_SLOT = 4;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter  int unsigned TAG_BITS   = aclink_pkg::TAG_BITS_DEF,
  parameter  int unsigned SLOT_BITS  = aclink_pkg::SLOT_BITS_DEF,
  parameter  int unsigned NUM_SLOTS  = aclink_pkg::NUM_SLOTS_DEF,
  localparam int unsigned FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS),
  localparam int unsigned SIDX_W     = $clog2(NUM_SLOTS + 1),
  localparam int unsigned OFFS_W     = $clog2(SLOT_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SIDX_W-1:0] cur_slot_o,
  output logic [OFFS_W-1:0] cur_offs_o,
  output logic [SIDX_W-1:0] nxt_slot_o,
  output logic [OFFS_W-1:0] nxt_offs_o,
  output logic              frame_end_o,
  output logic              sync_o,
  output logic              frame_done_o
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] RST_CNT  = CNT_W'(FRAME_BITS - 2);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(TAG_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  function automatic logic [SIDX_W+OFFS_W-1:0] locate(input logic [CNT_W-1:0] c);
    int unsigned ci, s, o;
    ci = int'(c);
    if (ci < TAG_BITS) begin
      s = 0;
      o = ci;
    end else begin
      s = (ci - TAG_BITS) / SLOT_BITS + 1;
      o = (ci - TAG_BITS) % SLOT_BITS;
    end
    return {SIDX_W'(s), OFFS_W'(o)};
  endfunction

  assign cnt_nxt     = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  assign frame_end_o = (cnt_q == LAST);
  assign {cur_slot_o, cur_offs_o} = locate(cnt_q);
  assign {nxt_slot_o, nxt_offs_o} = locate(cnt_nxt);

  // sync leads the tag by one bit so the codec sees it before bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= RST_CNT;
      sync_o       <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      cnt_q        <= cnt_nxt;
      sync_o       <= (cnt_nxt == LAST) || (cnt_nxt < SYNC_END);
      frame_done_o <= frame_end_o;
    end
  end

  // checker state
  logic             sync_d_q, seen_q;
  logic [CNT_W:0]   hi_run_q, gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d_q <= 1'b0;
      seen_q   <= 1'b0;
      hi_run_q <= '0;
      gap_q    <= '0;
    end else begin
      sync_d_q <= sync_o;
      hi_run_q <= sync_o ? hi_run_q + 1'b1 : '0;
      if (sync_o && !sync_d_q) begin
        gap_q  <= (CNT_W+1)'(1);
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  p_sync_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !sync_d_q && seen_q) |-> (gap_q == (CNT_W+1)'(FRAME_BITS)));

  p_sync_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_o && sync_d_q) |-> (hi_run_q == (CNT_W+1)'(TAG_BITS)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  p_done_in_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (sync_o && sync_d_q));
endmodule

// File: rtl/aclink_tx_serializer.sv
module aclink_tx_serializer #(
  parameter  int unsigned TAG_BITS    = aclink_pkg::TAG_BITS_DEF,
  parameter  int unsigned SLOT_BITS   = aclink_pkg::SLOT_BITS_DEF,
  parameter  int unsigned NUM_SLOTS   = aclink_pkg::NUM_SLOTS_DEF,
  parameter  int unsigned SAMPLE_BITS = aclink_pkg::SAMPLE_BITS_DEF,
  localparam int unsigned SIDX_W      = $clog2(NUM_SLOTS + 1),
  localparam int unsigned OFFS_W      = $clog2(SLOT_BITS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [SIDX_W-1:0]      nxt_slot_i,
  input  logic [OFFS_W-1:0]      nxt_offs_i,
  input  logic [SIDX_W-1:0]      cur_slot_i,
  input  logic [OFFS_W-1:0]      cur_offs_i,
  input  logic                   cmd_valid_i,
  input  logic [SLOT_BITS-1:0]   cmd_addr_i,
  input  logic [SLOT_BITS-1:0]   cmd_data_i,
  input  logic                   pcm_valid_i,
  input  logic [SAMPLE_BITS-1:0] left_i,
  input  logic [SAMPLE_BITS-1:0] right_i,
  output logic                   sdata_o
);
  import aclink_pkg::*;

  localparam int unsigned PAD_BITS = SLOT_BITS - SAMPLE_BITS;
  localparam int unsigned TAG_PAD  = SLOT_BITS - TAG_BITS;

  logic [TAG_BITS-1:0]  tag_fresh, tag_q;
  logic [SLOT_BITS-1:0] addr_q, data_q, left_q, right_q;
  logic [SLOT_BITS-1:0] slot_w [0:NUM_SLOTS];
  logic [SLOT_BITS-1:0] sel_w;
  logic [OFFS_W-1:0]    bit_pos;
  logic                 next_bit;

  always_comb begin
    tag_fresh = '0;
    tag_fresh[TAG_BITS-1]               = cmd_valid_i | pcm_valid_i;
    tag_fresh[TAG_BITS-1-SLOT_CMD_ADDR] = cmd_valid_i;
    tag_fresh[TAG_BITS-1-SLOT_CMD_DATA] = cmd_valid_i;
    tag_fresh[TAG_BITS-1-SLOT_PCM_L]    = pcm_valid_i;
    tag_fresh[TAG_BITS-1-SLOT_PCM_R]    = pcm_valid_i;
  end

  assign slot_w[SLOT_TAG]      = SLOT_BITS'(tag_q) << TAG_PAD;
  assign slot_w[SLOT_CMD_ADDR] = addr_q;
  assign slot_w[SLOT_CMD_DATA] = data_q;
  assign slot_w[SLOT_PCM_L]    = left_q;
  assign slot_w[SLOT_PCM_R]    = right_q;

  for (genvar k = LAST_USED_SLOT + 1; k <= NUM_SLOTS; k++) begin : g_idle_slot
    assign slot_w[k] = '0;
  end

  assign sel_w   = slot_w[nxt_slot_i];
  assign bit_pos = OFFS_W'(SLOT_BITS - 1) - nxt_offs_i;
  // bit 0 of a new frame leaves while the held words are being replaced
  assign next_bit = load_i ? tag_fresh[TAG_BITS-1] : sel_w[bit_pos];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      sdata_o <= 1'b0;
    end else begin
      sdata_o <= next_bit;
      if (load_i) begin
        tag_q   <= tag_fresh;
        addr_q  <= cmd_valid_i ? cmd_addr_i : '0;
        data_q  <= cmd_valid_i ? cmd_data_i : '0;
        left_q  <= pcm_valid_i ? (SLOT_BITS'(left_i) << PAD_BITS) : '0;
        right_q <= pcm_valid_i ? (SLOT_BITS'(right_i) << PAD_BITS) : '0;
      end
    end
  end

  p_pad_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cur_slot_i == SIDX_W'(SLOT_PCM_L)) || (cur_slot_i == SIDX_W'(SLOT_PCM_R)))
     && (cur_offs_i >= OFFS_W'(SAMPLE_BITS))) |-> !sdata_o);

  p_idle_slot_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_slot_i > SIDX_W'(LAST_USED_SLOT)) |-> !sdata_o);

  p_tag_spare_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_slot_i == SIDX_W'(SLOT_TAG)) && (cur_offs_i > OFFS_W'(LAST_USED_SLOT))) |-> !sdata_o);
endmodule

// File: rtl/aclink_rx_deserializer.sv
module aclink_rx_deserializer #(
  parameter  int unsigned TAG_BITS    = aclink_pkg::TAG_BITS_DEF,
  parameter  int unsigned SLOT_BITS   = aclink_pkg::SLOT_BITS_DEF,
  parameter  int unsigned NUM_SLOTS   = aclink_pkg::NUM_SLOTS_DEF,
  parameter  int unsigned SAMPLE_BITS = aclink_pkg::SAMPLE_BITS_DEF,
  localparam int unsigned SIDX_W      = $clog2(NUM_SLOTS + 1),
  localparam int unsigned OFFS_W      = $clog2(SLOT_BITS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sdata_i,
  input  logic [SIDX_W-1:0]      cur_slot_i,
  input  logic [OFFS_W-1:0]      cur_offs_i,
  input  logic                   frame_end_i,
  input  logic                   frame_done_i,
  output logic [TAG_BITS-1:0]    tag_o,
  output logic [SLOT_BITS-1:0]   stat_addr_o,
  output logic [SLOT_BITS-1:0]   stat_data_o,
  output logic [SAMPLE_BITS-1:0] left_o,
  output logic [SAMPLE_BITS-1:0] right_o
);
  import aclink_pkg::*;

  logic [SLOT_BITS-1:0] sh_q, word_in;
  logic [TAG_BITS-1:0]  tag_st_q;
  logic [SLOT_BITS-1:0] st_q [1:LAST_USED_SLOT];

  assign word_in = {sh_q[SLOT_BITS-2:0], sdata_i};

  // capture on falling edge; commit each slot on its last bit
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      tag_st_q <= '0;
      for (int k = 1; k <= LAST_USED_SLOT; k++) st_q[k] <= '0;
    end else begin
      sh_q <= word_in;
      if (cur_slot_i == SIDX_W'(SLOT_TAG) && cur_offs_i == OFFS_W'(TAG_BITS - 1))
        tag_st_q <= word_in[TAG_BITS-1:0];
      for (int k = 1; k <= LAST_USED_SLOT; k++) begin
        if (cur_slot_i == SIDX_W'(k) && cur_offs_i == OFFS_W'(SLOT_BITS - 1))
          st_q[k] <= word_in;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o       <= '0;
      stat_addr_o <= '0;
      stat_data_o <= '0;
      left_o      <= '0;
      right_o     <= '0;
    end else if (frame_end_i) begin
      tag_o       <= tag_st_q;
      stat_addr_o <= st_q[SLOT_CMD_ADDR];
      stat_data_o <= st_q[SLOT_CMD_DATA];
      left_o      <= st_q[SLOT_PCM_L][SLOT_BITS-1 -: SAMPLE_BITS];
      right_o     <= st_q[SLOT_PCM_R][SLOT_BITS-1 -: SAMPLE_BITS];
    end
  end

  p_rx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |-> ($stable(tag_o) && $stable(stat_addr_o) && $stable(stat_data_o)
                       && $stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/aclink_frame_ctrl.sv
module aclink_frame_ctrl #(
  parameter  int unsigned TAG_BITS    = aclink_pkg::TAG_BITS_DEF,
  parameter  int unsigned SLOT_BITS   = aclink_pkg::SLOT_BITS_DEF,
  parameter  int unsigned NUM_SLOTS   = aclink_pkg::NUM_SLOTS_DEF,
  parameter  int unsigned SAMPLE_BITS = aclink_pkg::SAMPLE_BITS_DEF
) (
  input  logic                   bit_clk_i,
  input  logic                   rst_ni,
  input  logic                   sdata_in_i,
  output logic                   sync_o,
  output logic                   sdata_out_o,
  output logic                   frame_done_o,
  input  logic                   tx_cmd_valid_i,
  input  logic [SLOT_BITS-1:0]   tx_cmd_addr_i,
  input  logic [SLOT_BITS-1:0]   tx_cmd_data_i,
  input  logic                   tx_pcm_valid_i,
  input  logic [SAMPLE_BITS-1:0] tx_left_i,
  input  logic [SAMPLE_BITS-1:0] tx_right_i,
  output logic [TAG_BITS-1:0]    rx_tag_o,
  output logic [SLOT_BITS-1:0]   rx_stat_addr_o,
  output logic [SLOT_BITS-1:0]   rx_stat_data_o,
  output logic [SAMPLE_BITS-1:0] rx_left_o,
  output logic [SAMPLE_BITS-1:0] rx_right_o
);
  localparam int unsigned SIDX_W = $clog2(NUM_SLOTS + 1);
  localparam int unsigned OFFS_W = $clog2(SLOT_BITS);

  logic [SIDX_W-1:0] cur_slot, nxt_slot;
  logic [OFFS_W-1:0] cur_offs, nxt_offs;
  logic              frame_end;

  aclink_frame_timer #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) u_timer (
    .clk_i        (bit_clk_i),
    .rst_ni       (rst_ni),
    .cur_slot_o   (cur_slot),
    .cur_offs_o   (cur_offs),
    .nxt_slot_o   (nxt_slot),
    .nxt_offs_o   (nxt_offs),
    .frame_end_o  (frame_end),
    .sync_o       (sync_o),
    .frame_done_o (frame_done_o)
  );

  aclink_tx_serializer #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .SAMPLE_BITS(SAMPLE_BITS)
  ) u_tx (
    .clk_i       (bit_clk_i),
    .rst_ni      (rst_ni),
    .load_i      (frame_end),
    .nxt_slot_i  (nxt_slot),
    .nxt_offs_i  (nxt_offs),
    .cur_slot_i  (cur_slot),
    .cur_offs_i  (cur_offs),
    .cmd_valid_i (tx_cmd_valid_i),
    .cmd_addr_i  (tx_cmd_addr_i),
    .cmd_data_i  (tx_cmd_data_i),
    .pcm_valid_i (tx_pcm_valid_i),
    .left_i      (tx_left_i),
    .right_i     (tx_right_i),
    .sdata_o     (sdata_out_o)
  );

  aclink_rx_deserializer #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .SAMPLE_BITS(SAMPLE_BITS)
  ) u_rx (
    .clk_i        (bit_clk_i),
    .rst_ni       (rst_ni),
    .sdata_i      (sdata_in_i),
    .cur_slot_i   (cur_slot),
    .cur_offs_i   (cur_offs),
    .frame_end_i  (frame_end),
    .frame_done_i (frame_done_o),
    .tag_o        (rx_tag_o),
    .stat_addr_o  (rx_stat_addr_o),
    .stat_data_o  (rx_stat_data_o),
    .left_o       (rx_left_o),
    .right_o      (rx_right_o)
  );

  p_first_tag_bit_r3: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    $rose(sync_o) |=> (sdata_out_o == ($past(tx_cmd_valid_i) | $past(tx_pcm_valid_i))));

  p_done_after_rise_r8: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    $rose(sync_o) |=> frame_done_o);
endmodule

// File: tb/tb_aclink_frame_ctrl.sv
`timescale 1ns/1ps
module tb_aclink_frame_ctrl;
  localparam int FB = 256;

  logic        bit_clk, rst_n, sdata_in;
  logic        sync, sdata_out, frame_done;
  logic        cmd_v, pcm_v;
  logic [19:0] cmd_a, cmd_d;
  logic [17:0] left, right;
  logic [15:0] rx_tag;
  logic [19:0] rx_sa, rx_sd;
  logic [17:0] rx_l, rx_r;

  aclink_frame_ctrl dut (
    .bit_clk_i(bit_clk), .rst_ni(rst_n), .sdata_in_i(sdata_in),
    .sync_o(sync), .sdata_out_o(sdata_out), .frame_done_o(frame_done),
    .tx_cmd_valid_i(cmd_v), .tx_cmd_addr_i(cmd_a), .tx_cmd_data_i(cmd_d),
    .tx_pcm_valid_i(pcm_v), .tx_left_i(left), .tx_right_i(right),
    .rx_tag_o(rx_tag), .rx_stat_addr_o(rx_sa), .rx_stat_data_o(rx_sd),
    .rx_left_o(rx_l), .rx_right_o(rx_r)
  );

  initial bit_clk = 1'b0;
  always #2.5 bit_clk = ~bit_clk;

  int checks = 0;
  int errors = 0;

  // expected receive words from the previous codec frame
  logic [15:0] pv_tag = '0;
  logic [19:0] pv_w1 = '0, pv_w2 = '0, pv_w3 = '0, pv_w4 = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] build(input logic [15:0] tag, input logic [19:0] w1, w2, w3, w4);
    logic [FB-1:0] f = '0;
    logic [19:0] w;
    for (int i = 0; i < 16; i++) f[i] = tag[15-i];
    for (int s = 1; s <= 12; s++) begin
      w = (s == 1) ? w1 : (s == 2) ? w2 : (s == 3) ? w3 : (s == 4) ? w4 : 20'h0;
      for (int i = 0; i < 20; i++) f[16 + (s-1)*20 + i] = w[19-i];
    end
    return f;
  endfunction

  function automatic logic [19:0] word_at(input logic [FB-1:0] f, input int s);
    logic [19:0] w;
    for (int i = 0; i < 20; i++) w[19-i] = f[16 + (s-1)*20 + i];
    return w;
  endfunction

  function automatic logic [15:0] tag_at(input logic [FB-1:0] f);
    logic [15:0] t;
    for (int i = 0; i < 16; i++) t[15-i] = f[i];
    return t;
  endfunction

  // entered on the falling edge where SYNC has just risen
  task automatic run_frame(input logic cv, input logic [19:0] ca, cd, input logic pv,
                           input logic [17:0] l, r, input logic [15:0] ctag,
                           input logic [19:0] c1, c2, c3, c4, input bit mid_change);
    logic [FB-1:0] cf, got;
    logic [15:0] etag;
    logic [19:0] e1, e2, e3, e4;
    int sync_bad = 0, done_bad = 0;
    cmd_v = cv; cmd_a = ca; cmd_d = cd; pcm_v = pv; left = l; right = r;
    etag = {cv | pv, cv, cv, pv, pv, 11'h0};
    e1 = cv ? ca : 20'h0;
    e2 = cv ? cd : 20'h0;
    e3 = pv ? {l, 2'b00} : 20'h0;
    e4 = pv ? {r, 2'b00} : 20'h0;
    cf = build(ctag, c1, c2, c3, c4);
    got = '0;
    for (int k = 0; k < FB; k++) begin
      @(posedge bit_clk);
      #1 sdata_in = cf[k];
      @(negedge bit_clk);
      got[k] = sdata_out;
      if (k < FB-1 && sync != (k < 15)) sync_bad++;
      if (frame_done != (k == 0)) done_bad++;
      if (k == 0 || k == 120) begin
        chk(rx_tag == pv_tag, "R9 rx tag", 64'(rx_tag), 64'(pv_tag));
        chk(rx_sa == pv_w1 && rx_sd == pv_w2, "R9 rx status words",
            {rx_sa, rx_sd}, {pv_w1, pv_w2});
        chk(rx_l == pv_w3[19:2] && rx_r == pv_w4[19:2], "R9 rx samples",
            {rx_l, rx_r}, {pv_w3[19:2], pv_w4[19:2]});
      end
      if (mid_change && k == 3) begin
        // R7: late changes must not reach the frame in flight
        cmd_v = ~cv; cmd_a = ~ca; cmd_d = ~cd; pcm_v = ~pv; left = ~l; right = ~r;
      end
    end
    chk(sync == 1'b1, "R1 next SYNC rise after 256 bits", 64'(sync), 64'd1);
    chk(sync_bad == 0, "R2 SYNC high 16 low 240", 64'(sync_bad), 64'd0);
    chk(done_bad == 0, "R8 single frame_done at bit 0", 64'(done_bad), 64'd0);
    chk(got[0] == (cv | pv), "R3 first bit is valid-frame", 64'(got[0]), 64'(cv | pv));
    chk(tag_at(got) == etag, "R4 tag slot", 64'(tag_at(got)), 64'(etag));
    chk(word_at(got, 1) == e1 && word_at(got, 2) == e2, "R5 command slots",
        {word_at(got, 1), word_at(got, 2)}, {e1, e2});
    chk(word_at(got, 3) == e3 && word_at(got, 4) == e4, "R6 pcm slots",
        {word_at(got, 3), word_at(got, 4)}, {e3, e4});
    chk(got[FB-1:96] == '0, "R6 slots 5-12 zero", 64'(got[FB-1:96] != '0), 64'd0);
    if (mid_change)
      chk(word_at(got, 3) == e3, "R7 inputs sampled at frame start", 64'(word_at(got, 3)), 64'(e3));
    pv_tag = ctag; pv_w1 = c1; pv_w2 = c2; pv_w3 = c3; pv_w4 = c4;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; sdata_in = 1'b0;
    cmd_v = 1'b0; pcm_v = 1'b0; cmd_a = '0; cmd_d = '0; left = '0; right = '0;
    repeat (3) @(negedge bit_clk);
    chk(sync == 1'b0 && sdata_out == 1'b0 && frame_done == 1'b0, "R10 serial outputs in reset",
        {sync, sdata_out, frame_done}, 64'd0);
    chk(rx_tag == '0 && rx_sa == '0 && rx_sd == '0 && rx_l == '0 && rx_r == '0,
        "R10 rx outputs in reset", {rx_tag, rx_l, rx_r}, 64'd0);
    rst_n = 1'b1;
    @(posedge bit_clk);
    @(negedge bit_clk);
    chk(sync == 1'b1, "R10 SYNC rises at first edge", 64'(sync), 64'd1);
    chk(frame_done == 1'b0, "R10 no strobe before first frame", 64'(frame_done), 64'd0);
  endtask

  task automatic test_idle();
    run_frame(1'b0, 20'h0, 20'h0, 1'b0, 18'h0, 18'h0,
              16'h9800, 20'h12345, 20'hABCDE, 20'h55554, 20'hAAAA8, 1'b0);
  endtask

  task automatic test_pcm();
    run_frame(1'b0, 20'h77777, 20'h66666, 1'b1, 18'h2ABCD, 18'h1F00F,
              16'hF800, 20'h0F0F0, 20'hF0F0F, 20'h3C3C0, 20'hC3C3C, 1'b0);
  endtask

  task automatic test_cmd();
    run_frame(1'b1, 20'h82000, 20'h80800, 1'b0, 18'h3FFFF, 18'h3FFFF,
              16'hE000, 20'h02000, 20'h1F1F0, 20'h00004, 20'h80000, 1'b0);
  endtask

  task automatic test_late_change();
    run_frame(1'b1, 20'h13579, 20'h2468A, 1'b1, 18'h12345, 18'h2A5A5,
              16'h8800, 20'h00001, 20'h80000, 20'h40000, 20'h00002, 1'b1);
  endtask

  task automatic test_full_scale();
    run_frame(1'b1, 20'hFFFFF, 20'hFFFFF, 1'b1, 18'h3FFFF, 18'h3FFFF,
              16'hFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 1'b0);
  endtask

  task automatic test_flush();
    run_frame(1'b0, 20'h0, 20'h0, 1'b1, 18'h00001, 18'h20000,
              16'h0000, 20'h0, 20'h0, 20'h0, 20'h0, 1'b0);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_idle();
    test_pcm();
    test_cmd();
    test_late_change();
    test_full_scale();
    test_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule